// File: doc/BRIEF.md
# Time-Shared Eight-Tap FIR Filter

This block computes a finite impulse response filter of eight taps using a single multiplier and accumulator. The multiplier is reused once per clock across the taps. A register chain holds the newest input sample and the seven before it. Two selectors feed the multiply-add stage one stored sample and its matching coefficient per cycle, stepping through the taps from the newest sample to the oldest. After the last tap the full sum is registered and flagged valid for one cycle.

A producer presents a sample with a valid strobe whenever `busy` is low. The filter then needs eight cycles to form the next output. It lowers `busy` during the last of those cycles, so a new sample can be taken on the same edge that registers the previous result. Coefficients sit in registers written one at a time through a small write port. All arithmetic is two's complement, and the accumulator is wide enough that no input pattern can overflow it.

Top module: `fir_tm8`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0, `out_y` is 0, and every stored sample and coefficient is 0. The first output after reset therefore sees zeros in all older sample slots.
- R2: A cycle with `coef_we` high writes `coef_data` into coefficient slot `coef_addr`. Slot 0 multiplies the newest sample and slot k multiplies the sample accepted k samples earlier.
- R3: A sample is accepted on a rising edge where `in_valid` is 1 and `busy` is 0. It becomes the newest entry, every older entry moves one slot older, and the oldest entry is discarded.
- R4: `out_y` equals the sum over k = 0..TAPS-1 of coefficient k times sample k, with samples and coefficients signed two's complement. The sum is given at the full width DATA_W+COEF_W+clog2(TAPS) bits, so the result is exact even when every term is full scale.
- R5: `out_valid` is high for exactly one cycle, and it rises TAPS clock edges after the edge that accepted the sample. `out_y` changes only on that edge and then holds until the next result.
- R6: `busy` is 1 from the accept edge through the following TAPS-1 cycles, and it is 0 in the last step cycle. As a result, samples can be accepted back to back, one every TAPS cycles.
- R7: A sample presented while `busy` is 1 is ignored. The stored samples do not change and no extra output is produced.
- R8: The accumulator restarts from zero for each accepted sample, so no output contains terms left over from an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Input sample, signed |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | clog2(TAPS) | Coefficient slot to write |
| coef_data | input | COEF_W | Coefficient value, signed |
| busy | output | 1 | High while a new sample cannot be taken |
| out_valid | output | 1 | One-cycle result strobe |
| out_y | output | DATA_W+COEF_W+clog2(TAPS) | Filter output, signed |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 16-bit coefficients and eight taps, which gives a 35-bit result. At this width the extreme sums are within reach. Eight products of -32768 times -32768 give +2^33, and eight products of -32768 times +32767 give the most negative reachable sum, so the guard bits are checked at both ends. With eight taps, back-to-back acceptance, samples injected while busy and impulse responses that read out each coefficient slot can all be covered within a few hundred blocks.

// File: rtl/fir_tm8_pkg.sv
package fir_tm8_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  function automatic int sum_w(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_tm8_ctrl.sv
module fir_tm8_ctrl
  import fir_tm8_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             accept,
  output logic             busy,
  output logic             step_en,
  output logic             last_step,
  output logic [IDX_W-1:0] step
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] step_q, step_d;

  assign last_step = (phase_q == PH_RUN) && (step_q == LAST_IDX);
  assign busy      = (phase_q == PH_RUN) && (step_q != LAST_IDX);
  assign accept    = in_valid && !busy;
  assign step_en   = (phase_q == PH_RUN);
  assign step      = step_q;

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    if (accept) begin
      phase_d = PH_RUN;
      step_d  = '0;
    end else if (phase_q == PH_RUN) begin
      if (last_step) begin
        phase_d = PH_IDLE;
        step_d  = '0;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end
endmodule

// File: rtl/fir_tm8_delay.sv
module fir_tm8_delay #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int IDX_W  = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  sel,
  output logic [DATA_W-1:0] tap_out
);
  logic [DATA_W-1:0] slot_q [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q[0] <= '0;
    end else if (shift_en) begin
      slot_q[0] <= din;
    end
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (shift_en) begin
        slot_q[g] <= slot_q[g-1];
      end
    end
  end

  assign tap_out = slot_q[sel];
endmodule

// File: rtl/fir_tm8_coef.sv
module fir_tm8_coef #(
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int IDX_W  = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [IDX_W-1:0]  sel,
  output logic [COEF_W-1:0] coef_out
);
  logic [COEF_W-1:0] bank_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    logic wr_hit;
    assign wr_hit = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (wr_hit) begin
        bank_q[g] <= wdata;
      end
    end
  end

  assign coef_out = bank_q[sel];
endmodule

// File: rtl/fir_tm8_mac.sv
module fir_tm8_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_en,
  input  logic              last_step,
  input  logic [DATA_W-1:0] x,
  input  logic [COEF_W-1:0] h,
  output logic [ACC_W-1:0]  y,
  output logic              y_valid
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [ACC_W-1:0]  y_q, y_d;
  logic                     v_q, v_d;

  assign prod = $signed(x) * $signed(h);
  assign sum  = acc_q + ACC_W'(prod);

  always_comb begin
    acc_d = acc_q;
    if (start) begin
      acc_d = '0;
    end else if (step_en) begin
      acc_d = sum;
    end
    y_d = last_step ? sum : y_q;
    v_d = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      y_q   <= '0;
      v_q   <= 1'b0;
    end else begin
      acc_q <= acc_d;
      y_q   <= y_d;
      v_q   <= v_d;
    end
  end

  assign y       = y_q;
  assign y_valid = v_q;
endmodule

// File: rtl/fir_tm8.sv
module fir_tm8
  import fir_tm8_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int IDX_W  = $clog2(TAPS),
  parameter int ACC_W  = sum_w(DATA_W, COEF_W, TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_addr,
  input  logic [COEF_W-1:0] coef_data,
  output logic              busy,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_y
);
  logic              accept;
  logic              step_en;
  logic              last_step;
  logic [IDX_W-1:0]  step;
  logic [DATA_W-1:0] x_sel;
  logic [COEF_W-1:0] h_sel;

  fir_tm8_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .busy      (busy),
    .step_en   (step_en),
    .last_step (last_step),
    .step      (step)
  );

  fir_tm8_delay #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_sample),
    .sel      (step),
    .tap_out  (x_sel)
  );

  fir_tm8_coef #(.COEF_W(COEF_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (coef_we),
    .waddr    (coef_addr),
    .wdata    (coef_data),
    .sel      (step),
    .coef_out (h_sel)
  );

  fir_tm8_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .x         (x_sel),
    .h         (h_sel),
    .y         (out_y),
    .y_valid   (out_valid)
  );
endmodule

// File: rtl/fir_tm8_chk.sv
module fir_tm8_chk #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             busy,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_y
);
  localparam int CW = $clog2(TAPS) + 1;

  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic          take;
  logic          final_step;

  assign take       = in_valid && !busy;
  assign final_step = act_q && (cnt_q == CW'(TAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (take) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (final_step) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    final_step |=> out_valid); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !final_step |=> !out_valid); // R7
  AST_BUSY_MID_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !final_step) |-> busy); // R6
  AST_FREE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (final_step || !act_q) |-> !busy); // R6
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_y)); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && TAPS > 1) |=> busy); // R3
endmodule

bind fir_tm8 fir_tm8_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .out_y     (out_y)
);

// File: tb/sim_fir_tm8.sv
`timescale 1ns/1ps
module sim_fir_tm8;
  localparam int DW   = 16;
  localparam int CWD  = 16;
  localparam int TAPS = 8;
  localparam int IW   = $clog2(TAPS);
  localparam int AW   = DW + CWD + IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  logic          coef_we;
  logic [IW-1:0] coef_addr;
  logic [CWD-1:0] coef_data;
  logic          busy;
  logic          out_valid;
  logic [AW-1:0] out_y;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  longint hist [TAPS];
  longint hc   [TAPS];
  bit     pending = 0;
  longint pend_exp;
  string  pend_tag;

  always #10 clk = ~clk;

  fir_tm8 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .busy(busy), .out_valid(out_valid), .out_y(out_y)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint yval();
    logic signed [AW-1:0] s;
    s = out_y;
    return longint'(s);
  endfunction

  function automatic longint model_y();
    longint acc = 0;
    for (int k = 0; k < TAPS; k++) acc += hist[k] * hc[k];
    return acc;
  endfunction

  function automatic longint sx(input logic [15:0] v);
    logic signed [15:0] t;
    t = v;
    return longint'(t);
  endfunction

  task automatic check_pending();
    chk(out_valid === 1'b1, "R5", longint'(out_valid), 1);
    chk(yval() == pend_exp, pend_tag, yval(), pend_exp);
    pending = 0;
  endtask

  task automatic wr_coef(input int idx, input logic [CWD-1:0] v);
    coef_we = 1'b1; coef_addr = IW'(idx); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    hc[idx] = sx(v);
  endtask

  task automatic feed(input logic [DW-1:0] s, input string tag,
                      input bit inject, input logic [DW-1:0] junk);
    in_valid = 1'b1; in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
    if (pending) check_pending();
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0]  = sx(s);
    pend_exp = model_y();
    pend_tag = inject ? "R7" : tag;
    pending  = 1;
    chk(busy === 1'b1, "R6", longint'(busy), 1);
    for (int k = 1; k < TAPS; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, inject ? "R7" : "R5", longint'(out_valid), 0);
      chk(busy === (k < TAPS - 1), "R6", longint'(busy), longint'(k < TAPS - 1));
      if (inject && k == 2) begin in_valid = 1'b1; in_sample = junk; end
      if (inject && k == 3) in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    check_pending();
    @(negedge clk);
    chk(out_valid === 1'b0, "R5", longint'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < TAPS; k++) begin hist[k] = 0; hc[k] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", longint'(busy), 0);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(yval() == 0, "R1", yval(), 0);

    // R1 first output sees zeroed history
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'($urandom));
    feed(16'($urandom), "R1", 0, '0);
    drain();

    // R3 flush with zeros, R2 impulse reads each coefficient slot
    for (int k = 0; k < TAPS; k++) feed(16'd0, "R3", 0, '0);
    drain();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'(100 * (k + 1) - 450));
    feed(16'd1, "R2", 0, '0);
    for (int k = 1; k < TAPS + 1; k++) feed(16'd0, "R2", 0, '0);
    drain();

    // R4 full-scale extremes
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h8000);
    for (int k = 0; k < TAPS; k++) feed(16'h8000, "R4", 0, '0);
    drain();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h7FFF);
    for (int k = 0; k < TAPS; k++) feed(16'h8000, "R4", 0, '0);
    drain();

    // R7 sample while busy is ignored
    feed(16'd1234, "R7", 1, 16'h7FFF);
    drain();
    feed(16'hFF00, "R7", 1, 16'h8000);
    feed(16'd55, "R8", 0, '0);
    drain();

    // random blocks, R8 restart of accumulation between results
    for (int b = 0; b < 120; b++) begin
      if (b % 16 == 0 && !pending) wr_coef(int'($urandom % TAPS), 16'($urandom));
      feed(16'($urandom), "R8", ($urandom % 4) == 0, 16'($urandom));
      if (($urandom % 3) == 0) begin
        drain();
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    if (pending) drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule